// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block sequences the power state of a data converter between full operation, a light low-power state and a deep low-power state. In the light state the conversion core is powered down and the reference circuits keep running. In the deep state both are powered down. The block drives one power-down enable for the core and one for the references. It also drives a flag that tells downstream logic whether converter output can be trusted.

The power request comes from one of two places. In register mode it is a two-bit field written by a configuration interface that lies outside this block. In strap mode it is a single pad input that can only ask for the deep state. The pad input passes through a parameterised synchronizer before it is used.

Recovery lengths are derived from parameters. Light-state recovery is a fixed cycle count, optionally extended by a DC-settle interval. Deep-state recovery is a time interval. Both time intervals are given in microseconds and converted to cycles through a clock-frequency parameter in kHz, rounding up.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and right after it, `core_pd`, `ref_pd` and `data_valid` are 0. With a run request held, `data_valid` rises exactly SLEEP_CYC clock edges after reset is released, because power-up is treated as a deep-state recovery.
- R2: In register mode (`cfg_from_regs`=1), `reg_pwr_sel` is decoded as follows: 2'b00 requests run, 2'b01 requests the light state, and 2'b10 or 2'b11 request the deep state.
- R3: In strap mode (`cfg_from_regs`=0), `strap_sleep`=1 requests the deep state and 0 requests run, and `reg_pwr_sel` has no effect. The pad passes through SYNC_STAGES flops, so the state changes on clock edge SYNC_STAGES+1 after the pad changes.
- R4: In the light state `core_pd`=1 and `ref_pd`=0. In the deep state both are 1.
- R5: From the running state, a low-power request clears `data_valid` on the same edge that raises `core_pd`.
- R6: When waking from the light state, `data_valid` rises exactly NAP_WAKE_CYCLES edges after `core_pd` falls. If `dc_settle_en`=1 at the edge where `core_pd` falls, it rises SETTLE_CYC edges later than that.
- R7: When waking from the deep state, `data_valid` rises exactly SLEEP_CYC edges after `core_pd` falls, whatever the value of `dc_settle_en`.
- R8: A deep-state request while in the light state raises `ref_pd` on the next edge.
- R9: A light-state request while in the deep state powers the references back up while the core stays down. The next wake then uses the deep-state recovery length.
- R10: A low-power request during recovery returns to that low-power state at the next edge. A later wake restarts the full recovery length from zero.
- R11: During recovery `core_pd`, `ref_pd` and `data_valid` are all 0. `data_valid` is never 1 while either power-down enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_from_regs | input | 1 | 1 = register-driven request, 0 = strap pad request |
| reg_pwr_sel | input | 2 | Register power request: 00 run, 01 light, 1x deep |
| strap_sleep | input | 1 | Pad request in strap mode: 1 deep, 0 run (asynchronous) |
| dc_settle_en | input | 1 | Adds the DC-settle interval to light-state recovery |
| core_pd | output | 1 | Power-down enable for the conversion core |
| ref_pd | output | 1 | Power-down enable for the reference circuits |
| data_valid | output | 1 | Converter output is valid |

## Verification
The checks focus on how soon a corrupted internal state becomes visible at the pins. A wrong state register shows up within one edge as a forbidden pin combination: the reference disabled while the core is on, or `data_valid` high while either power-down enable is set. A stale deep-state marker or a stale recovery count shows up only when `data_valid` rises, up to SLEEP_CYC cycles later, as a rise at the wrong edge. For that reason every recovery path is timed to the exact edge, and the reference model is compared on every clock.

// File: rtl/pwr_mode_seq_pkg.sv
package pwr_mode_seq_pkg;

    typedef enum logic [1:0] {
        REQ_RUN   = 2'd0,
        REQ_NAP   = 2'd1,
        REQ_SLEEP = 2'd2
    } pwr_req_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_NAP    = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKE   = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       cold;   // references were off since the last completed wake
    } seq_t;

    // microseconds to clock cycles, rounded up
    function automatic int unsigned us_to_cycles(int unsigned us, int unsigned khz);
        return (us * khz + 32'd999) / 32'd1000;
    endfunction

endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
    import pwr_mode_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_from_regs,
    input  logic [1:0] reg_pwr_sel,
    input  logic       strap_sleep,
    output pwr_req_e   req
);

    logic pin_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign pin_s = strap_sleep;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = strap_sleep;
                for (int i = 1; i < SYNC_STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign pin_s = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_comb begin
        if (cfg_from_regs) begin
            case (reg_pwr_sel)
                2'b00:   req = REQ_RUN;
                2'b01:   req = REQ_NAP;
                default: req = REQ_SLEEP;
            endcase
        end else begin
            req = pin_s ? REQ_SLEEP : REQ_RUN;
        end
    end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int CW          = 8,
    parameter int RESET_LIMIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        expire = run && (cur_q.cnt == cur_q.lim - 1'b1);
        if (start) begin
            nxt_d.cnt = '0;
            nxt_d.lim = limit;
        end else if (run && !expire) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt <= '0;
            cur_q.lim <= CW'(RESET_LIMIT);
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R6: the count never reaches the latched limit
    p_cnt_below_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < cur_q.lim);

    // R10: every wake start restarts the count from zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_q.cnt == '0));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_seq_pkg::*;
#(
    parameter int CLK_FREQ_KHZ    = 125000,
    parameter int NAP_WAKE_CYCLES = 100,
    parameter int SLEEP_WAKE_US   = 2000,
    parameter int DC_SETTLE_US    = 50,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_from_regs,
    input  logic [1:0] reg_pwr_sel,
    input  logic       strap_sleep,
    input  logic       dc_settle_en,
    output logic       core_pd,
    output logic       ref_pd,
    output logic       data_valid
);

    localparam int SLEEP_CYC  = int'(us_to_cycles(SLEEP_WAKE_US, CLK_FREQ_KHZ));
    localparam int SETTLE_CYC = int'(us_to_cycles(DC_SETTLE_US, CLK_FREQ_KHZ));
    localparam int NAP_CYC    = NAP_WAKE_CYCLES;
    localparam int NAP_LONG   = NAP_CYC + SETTLE_CYC;
    localparam int MAX_CYC    = (SLEEP_CYC > NAP_LONG) ? SLEEP_CYC : NAP_LONG;
    localparam int CW         = $clog2(MAX_CYC + 1);

    pwr_req_e      req;
    seq_t          seq_q, seq_d;
    logic          tmr_start, tmr_run, tmr_expire;
    logic [CW-1:0] limit_sel;

    pwr_req_decode #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_from_regs(cfg_from_regs),
        .reg_pwr_sel  (reg_pwr_sel),
        .strap_sleep  (strap_sleep),
        .req          (req)
    );

    pwr_wake_timer #(.CW(CW), .RESET_LIMIT(SLEEP_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .limit (limit_sel),
        .expire(tmr_expire)
    );

    always_comb begin
        if (seq_q.cold)        limit_sel = CW'(SLEEP_CYC);
        else if (dc_settle_en) limit_sel = CW'(NAP_LONG);
        else                   limit_sel = CW'(NAP_CYC);
    end

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        case (seq_q.st)
            ST_ACTIVE: begin
                if (req == REQ_SLEEP) begin
                    seq_d.st   = ST_SLEEP;
                    seq_d.cold = 1'b1;
                end else if (req == REQ_NAP) begin
                    seq_d.st = ST_NAP;
                end
            end
            ST_NAP: begin
                if (req == REQ_SLEEP) begin
                    seq_d.st   = ST_SLEEP;
                    seq_d.cold = 1'b1;
                end else if (req == REQ_RUN) begin
                    seq_d.st  = ST_WAKE;
                    tmr_start = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (req == REQ_NAP) begin
                    seq_d.st = ST_NAP;
                end else if (req == REQ_RUN) begin
                    seq_d.st  = ST_WAKE;
                    tmr_start = 1'b1;
                end
            end
            default: begin
                if (req == REQ_SLEEP) begin
                    seq_d.st   = ST_SLEEP;
                    seq_d.cold = 1'b1;
                end else if (req == REQ_NAP) begin
                    seq_d.st = ST_NAP;
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_expire) begin
                        seq_d.st   = ST_ACTIVE;
                        seq_d.cold = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_WAKE;
            seq_q.cold <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign core_pd    = (seq_q.st == ST_NAP) || (seq_q.st == ST_SLEEP);
    assign ref_pd     = (seq_q.st == ST_SLEEP);
    assign data_valid = (seq_q.st == ST_ACTIVE);

    // R4: references are never down while the core runs
    p_ref_needs_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pd |-> core_pd);

    // R11: valid output never coexists with a power-down enable
    p_valid_no_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (!core_pd && !ref_pd));

    // R5: a low-power request while running drops valid and powers down the core
    p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && req != REQ_RUN) |=> (!data_valid && core_pd));

    // R8: a deep request in the light state shuts the references next edge
    p_nap_to_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_pd && !ref_pd && req == REQ_SLEEP) |=> ref_pd);

    // R11: leaving a low-power state never jumps straight to valid
    p_no_instant_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_pd) |-> !data_valid);

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

    localparam int KHZ    = 100;
    localparam int NAPW   = 100;
    localparam int SLP_US = 2000;
    localparam int SET_US = 50;
    localparam int SYNC   = 2;
    localparam int E_SLP  = (SLP_US * KHZ + 999) / 1000;   // 200
    localparam int E_SET  = (SET_US * KHZ + 999) / 1000;   // 5

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_from_regs = 1'b1;
    logic [1:0] reg_pwr_sel = 2'b00;
    logic       strap_sleep = 1'b0;
    logic       dc_settle_en = 1'b0;
    logic       core_pd, ref_pd, data_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_seq #(
        .CLK_FREQ_KHZ(KHZ), .NAP_WAKE_CYCLES(NAPW), .SLEEP_WAKE_US(SLP_US),
        .DC_SETTLE_US(SET_US), .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_from_regs(cfg_from_regs),
        .reg_pwr_sel(reg_pwr_sel), .strap_sleep(strap_sleep),
        .dc_settle_en(dc_settle_en), .core_pd(core_pd), .ref_pd(ref_pd),
        .data_valid(data_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model: 0 running, 1 light, 2 deep, 3 recovering
    int m_mode = 3;
    int m_rem  = E_SLP;
    bit m_cold = 1'b1;
    bit pin_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 3; m_rem = E_SLP; m_cold = 1'b1;
            pin_hist = {};
            for (int i = 0; i < SYNC; i++) pin_hist.push_back(1'b0);
        end else begin
            int r;
            if (cfg_from_regs) r = (reg_pwr_sel == 2'b00) ? 0 : (reg_pwr_sel == 2'b01) ? 1 : 2;
            else               r = pin_hist[SYNC-1] ? 2 : 0;
            pin_hist.push_front(strap_sleep);
            void'(pin_hist.pop_back());
            if (r == 2) begin
                m_mode = 2; m_cold = 1'b1;
            end else if (r == 1) begin
                m_mode = 1;
            end else if (m_mode == 1 || m_mode == 2) begin
                m_mode = 3;
                m_rem  = m_cold ? E_SLP : (NAPW + (dc_settle_en ? E_SET : 0));
            end else if (m_mode == 3) begin
                m_rem--;
                if (m_rem == 0) begin m_mode = 0; m_cold = 1'b0; end
            end
        end
    end

    // R4 R5 R11: every-cycle comparison with the model
    always @(negedge clk) begin
        if (!done) begin
            int exp_v;
            exp_v = {(m_mode == 1 || m_mode == 2), (m_mode == 2), (m_mode == 0)};
            chk({core_pd, ref_pd, data_valid} == 3'(exp_v), "R4 R5 R11 model",
                int'({core_pd, ref_pd, data_valid}), exp_v);
        end
    end

    // counts edges from core_pd falling to data_valid rising
    task automatic wake_len(output int n);
        while (core_pd) @(negedge clk);
        n = 0;
        while (!data_valid) begin @(negedge clk); n++; end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        idle(3);
        // R1: reset values
        chk(!core_pd && !ref_pd && !data_valid, "R1 reset outputs",
            int'({core_pd, ref_pd, data_valid}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!data_valid) begin @(negedge clk); n++; end
        chk(n == E_SLP, "R1 power-up recovery", n, E_SLP);
        idle(3);

        // R2 R4 R5: register light request
        reg_pwr_sel = 2'b01;
        @(negedge clk);
        chk(core_pd && !ref_pd && !data_valid, "R2 R4 R5 nap entry",
            int'({core_pd, ref_pd, data_valid}), 4);
        idle(10);
        reg_pwr_sel = 2'b00;
        wake_len(n);
        chk(n == NAPW, "R6 nap wake", n, NAPW);

        // R6: with DC settle
        reg_pwr_sel = 2'b01; idle(5);
        dc_settle_en = 1'b1; reg_pwr_sel = 2'b00;
        wake_len(n);
        chk(n == NAPW + E_SET, "R6 nap wake settle", n, NAPW + E_SET);

        // R2 R4 R7: deep via 2'b11, settle enable ignored
        reg_pwr_sel = 2'b11;
        @(negedge clk);
        chk(core_pd && ref_pd && !data_valid, "R2 R4 sleep code 11",
            int'({core_pd, ref_pd, data_valid}), 6);
        reg_pwr_sel = 2'b10; idle(5);
        chk(core_pd && ref_pd, "R2 sleep code 10", int'({core_pd, ref_pd}), 3);
        reg_pwr_sel = 2'b00;
        wake_len(n);
        chk(n == E_SLP, "R7 sleep wake", n, E_SLP);
        dc_settle_en = 1'b0;

        // R8: light -> deep
        reg_pwr_sel = 2'b01; idle(4);
        reg_pwr_sel = 2'b10;
        @(negedge clk);
        chk(ref_pd && core_pd, "R8 nap to sleep", int'({core_pd, ref_pd}), 3);

        // R9: deep -> light -> run keeps the long recovery
        idle(4);
        reg_pwr_sel = 2'b01;
        @(negedge clk);
        chk(core_pd && !ref_pd, "R9 sleep to nap", int'({core_pd, ref_pd}), 2);
        idle(5);
        reg_pwr_sel = 2'b00;
        wake_len(n);
        chk(n == E_SLP, "R9 cold nap wake", n, E_SLP);

        // R10 R11: abort during recovery, then full restart
        reg_pwr_sel = 2'b01; idle(3);
        reg_pwr_sel = 2'b00; idle(50);
        chk(!core_pd && !ref_pd && !data_valid, "R11 during recovery",
            int'({core_pd, ref_pd, data_valid}), 0);
        reg_pwr_sel = 2'b01;
        @(negedge clk);
        chk(core_pd && !data_valid, "R10 abort to nap", int'({core_pd, data_valid}), 2);
        reg_pwr_sel = 2'b00;
        wake_len(n);
        chk(n == NAPW, "R10 restart full", n, NAPW);

        // R3: strap mode, light code in the register is ignored
        cfg_from_regs = 1'b0; reg_pwr_sel = 2'b01; strap_sleep = 1'b0;
        idle(4);
        chk(!core_pd && data_valid, "R3 reg field ignored",
            int'({core_pd, data_valid}), 1);
        strap_sleep = 1'b1;
        idle(SYNC);
        chk(!core_pd, "R3 pin latency early", int'(core_pd), 0);
        @(negedge clk);
        chk(core_pd && ref_pd, "R3 pin sleep", int'({core_pd, ref_pd}), 3);
        strap_sleep = 1'b0;
        wake_len(n);
        chk(n == E_SLP, "R3 R7 pin wake", n, E_SLP);
        idle(3);
        finish_run();
    end

endmodule